// File: doc/BRIEF.md
# Compare Control Shadow Register Stage

This block keeps the per-channel output control of a multi-channel compare timer: a main output enable, a complementary output enable and an output-mode code for each channel. Writes arrive one channel at a time on a small write port. A configuration input picks how a write takes effect. In direct mode it reaches the active outputs at once. In staged mode it is held in a staging copy. The staging copy is moved to the active outputs only when a commutation event occurs.

A second configuration input picks what counts as a commutation event. It is either the software commutation strobe alone, or the strobe together with any rising edge of the timer trigger input. All channels move together in one cycle, so a group of changes, such as a motor commutation step, reaches the outputs at the same instant. The block also routes each channel's DMA request: either from that channel's own compare event or from the counter update event.

Top module: `cmp_ctl_shadow`

## Requirements
- R1: While reset is held and after it is released, every active enable, complementary enable, mode field and DMA request output is 0.
- R2: With `cfg_preload` = 0, a write to channel c (with `wr_chan` = c, channels numbered from 0) appears on that channel's active outputs after the clock edge that samples it. Other channels do not change.
- R3: With `cfg_preload` = 1, a write does not change any active output until a commutation event occurs.
- R4: A commutation event with `cfg_preload` = 1 copies the staged values of all channels to the active outputs at the same clock edge.
- R5: With `cfg_trig_commute` = 0, edges on `trig_in` cause no transfer.
- R6: With `cfg_trig_commute` = 1, a cycle in which `trig_in` is 1 and was 0 in the previous cycle is a commutation event. A held high level or a falling edge is not a commutation event. The previous value is 0 after reset.
- R7: A write and a commutation event in the same cycle transfer the newly written value.
- R8: `dma_req` is registered. With `cfg_dma_on_update` = 0, bit c equals `chan_evt[c]` of the previous cycle. With `cfg_dma_on_update` = 1, every bit equals `upd_evt` of the previous cycle and `chan_evt` is ignored.
- R9: With `cfg_preload` = 0, the commutation strobe has no effect on the active outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_preload | input | 1 | 0 = direct writes, 1 = staged writes |
| cfg_trig_commute | input | 1 | 1 = a trigger rising edge also commutates |
| cfg_dma_on_update | input | 1 | 0 = DMA on channel event, 1 = DMA on update event |
| wr_en | input | 1 | Channel control write strobe |
| wr_chan | input | CH_W | Channel index of the write |
| wr_oe | input | 1 | Written main output enable |
| wr_oen | input | 1 | Written complementary output enable |
| wr_mode | input | MODE_W | Written output-mode code |
| com_strobe | input | 1 | Software commutation strobe |
| trig_in | input | 1 | Timer trigger input level |
| chan_evt | input | NUM_CH | Per-channel compare/capture event |
| upd_evt | input | 1 | Counter update event |
| act_oe | output | NUM_CH | Active main output enables |
| act_oen | output | NUM_CH | Active complementary enables |
| act_mode | output | NUM_CH*MODE_W | Active mode codes, channel c at bits c*MODE_W upward |
| dma_req | output | NUM_CH | Per-channel DMA request |

## Verification
The bench targets several corner cases, each with a distinct failure it would expose:
- A write that lands in the same cycle as a strobe or a trigger edge. A design that moves the old staged value here shows the stale mode.
- A trigger held high across several cycles. A level-sensitive detector would transfer repeatedly and leak writes made while the level is high.
- Trigger edges while edge commutation is off. These must leave the outputs frozen.
- Direct mode with a strobe. This must not disturb the outputs.
- DMA routing in both positions, with events on both sources at the same time. This catches a swapped or merged select.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

    typedef struct packed {
        logic preload;
        logic trig_commute;
        logic dma_on_update;
    } ccs_cfg_t;

    typedef struct packed {
        logic strobe;
        logic trig_rise;
        logic xfer;
    } ccs_evt_t;

    function automatic logic rise_of(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ccs_commute_evt.sv
module ccs_commute_evt
    import ccs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ccs_cfg_t cfg,
    input  logic     com_strobe,
    input  logic     trig_in,
    output ccs_evt_t evt
);
    logic trig_q;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= trig_in;
    end

    always_comb begin
        evt.strobe    = com_strobe;
        evt.trig_rise = rise_of(trig_in, trig_q);
        evt.xfer      = com_strobe | (cfg.trig_commute & evt.trig_rise);
    end

    AST_HELD_LEVEL_NO_XFER: assert property (@(posedge clk) disable iff (rst)
        (cfg.trig_commute && trig_in && $past(trig_in) && !$past(rst) && !com_strobe)
        |-> !evt.xfer) else $error("held trigger level commutated"); // R6

    AST_EDGE_OFF_NO_XFER: assert property (@(posedge clk) disable iff (rst)
        (!cfg.trig_commute && !com_strobe && trig_in && !$past(trig_in))
        |-> !evt.xfer) else $error("trigger edge commutated while disabled"); // R5

endmodule

// File: rtl/ccs_ctl_slot.sv
module ccs_ctl_slot #(
    parameter int unsigned MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              preload,
    input  logic              xfer,
    input  logic              wr_hit,
    input  logic              wr_oe,
    input  logic              wr_oen,
    input  logic [MODE_W-1:0] wr_mode,
    output logic              act_oe,
    output logic              act_oen,
    output logic [MODE_W-1:0] act_mode
);
    localparam int unsigned SLOT_W = MODE_W + 2;

    logic [SLOT_W-1:0] stage_q;
    logic [SLOT_W-1:0] stage_nxt;
    logic [SLOT_W-1:0] live_q;
    logic [SLOT_W-1:0] wr_word;

    assign wr_word   = {wr_oe, wr_oen, wr_mode};
    assign stage_nxt = wr_hit ? wr_word : stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            live_q  <= '0;
        end else begin
            stage_q <= stage_nxt;
            if (!preload) begin
                if (wr_hit) live_q <= wr_word;
            end else if (xfer) begin
                live_q <= stage_nxt;
            end
        end
    end

    assign {act_oe, act_oen, act_mode} = live_q;

    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!preload && wr_hit) |=> ({act_oe, act_oen, act_mode} ==
            $past({wr_oe, wr_oen, wr_mode}))) else $error("direct write lost"); // R2

    AST_STAGED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (preload && !xfer) |=> $stable({act_oe, act_oen, act_mode}))
        else $error("staged write leaked"); // R3

    AST_DIRECT_STROBE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!preload && !wr_hit) |=> $stable({act_oe, act_oen, act_mode}))
        else $error("direct mode changed without write"); // R9

endmodule

// File: rtl/ccs_dma_route.sv
module ccs_dma_route #(
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              on_update,
    input  logic [NUM_CH-1:0] chan_evt,
    input  logic              upd_evt,
    output logic [NUM_CH-1:0] dma_req
);
    always_ff @(posedge clk) begin
        if (rst)            dma_req <= '0;
        else if (on_update) dma_req <= {NUM_CH{upd_evt}};
        else                dma_req <= chan_evt;
    end

    AST_DMA_CHAN: assert property (@(posedge clk) disable iff (rst)
        !on_update |=> (dma_req == $past(chan_evt)))
        else $error("channel DMA route wrong"); // R8

    AST_DMA_UPD: assert property (@(posedge clk) disable iff (rst)
        on_update |=> (dma_req == {NUM_CH{$past(upd_evt)}}))
        else $error("update DMA route wrong"); // R8

endmodule

// File: rtl/cmp_ctl_shadow.sv
module cmp_ctl_shadow
    import ccs_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned MODE_W = 3,
    parameter int unsigned CH_W   = idx_width(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_preload,
    input  logic                     cfg_trig_commute,
    input  logic                     cfg_dma_on_update,
    input  logic                     wr_en,
    input  logic [CH_W-1:0]          wr_chan,
    input  logic                     wr_oe,
    input  logic                     wr_oen,
    input  logic [MODE_W-1:0]        wr_mode,
    input  logic                     com_strobe,
    input  logic                     trig_in,
    input  logic [NUM_CH-1:0]        chan_evt,
    input  logic                     upd_evt,
    output logic [NUM_CH-1:0]        act_oe,
    output logic [NUM_CH-1:0]        act_oen,
    output logic [NUM_CH*MODE_W-1:0] act_mode,
    output logic [NUM_CH-1:0]        dma_req
);
    ccs_cfg_t cfg;
    ccs_evt_t evt;
    logic [NUM_CH-1:0] wr_hit;

    assign cfg = '{preload: cfg_preload, trig_commute: cfg_trig_commute,
                   dma_on_update: cfg_dma_on_update};

    ccs_commute_evt u_evt (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .com_strobe (com_strobe),
        .trig_in    (trig_in),
        .evt        (evt)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
        assign wr_hit[c] = wr_en && (wr_chan == CH_W'(c));

        ccs_ctl_slot #(.MODE_W(MODE_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .preload  (cfg.preload),
            .xfer     (evt.xfer),
            .wr_hit   (wr_hit[c]),
            .wr_oe    (wr_oe),
            .wr_oen   (wr_oen),
            .wr_mode  (wr_mode),
            .act_oe   (act_oe[c]),
            .act_oen  (act_oen[c]),
            .act_mode (act_mode[c*MODE_W +: MODE_W])
        );
    end

    ccs_dma_route #(.NUM_CH(NUM_CH)) u_dma (
        .clk       (clk),
        .rst       (rst),
        .on_update (cfg.dma_on_update),
        .chan_evt  (chan_evt),
        .upd_evt   (upd_evt),
        .dma_req   (dma_req)
    );

    AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_hit)) else $error("write decoded to several channels"); // R2

endmodule

// File: tb/cmp_ctl_shadow_test.sv
module cmp_ctl_shadow_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int MW  = 3;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst, cfg_preload, cfg_trig_commute, cfg_dma_on_update;
    logic wr_en, wr_oe, wr_oen, com_strobe, trig_in, upd_evt;
    logic [1:0] wr_chan;
    logic [MW-1:0] wr_mode;
    logic [NCH-1:0] chan_evt, act_oe, act_oen, dma_req;
    logic [NCH*MW-1:0] act_mode;

    cmp_ctl_shadow #(.NUM_CH(NCH), .MODE_W(MW)) uut (
        .clk(clk), .rst(rst), .cfg_preload(cfg_preload),
        .cfg_trig_commute(cfg_trig_commute), .cfg_dma_on_update(cfg_dma_on_update),
        .wr_en(wr_en), .wr_chan(wr_chan), .wr_oe(wr_oe), .wr_oen(wr_oen),
        .wr_mode(wr_mode), .com_strobe(com_strobe), .trig_in(trig_in),
        .chan_evt(chan_evt), .upd_evt(upd_evt), .act_oe(act_oe),
        .act_oen(act_oen), .act_mode(act_mode), .dma_req(dma_req)
    );

    typedef struct packed {
        logic [NCH-1:0]    oe;
        logic [NCH-1:0]    oen;
        logic [NCH*MW-1:0] mode;
        logic [NCH-1:0]    dma;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int checks = 0;
    int errors = 0;

    // drive settings used by step()
    logic d_pre = 0, d_tc = 0, d_dsel = 0, d_wr = 0, d_oe = 0, d_oen = 0;
    logic d_stb = 0, d_trig = 0, d_upd = 0;
    logic [1:0] d_ch = 0;
    logic [MW-1:0] d_mode = 0;
    logic [NCH-1:0] d_chevt = 0;

    // reference state built from the requirements
    logic [NCH-1:0] m_pre_oe = 0, m_pre_oen = 0, m_act_oe = 0, m_act_oen = 0, m_dma = 0;
    logic [NCH*MW-1:0] m_pre_mode = 0, m_act_mode = 0;
    logic m_tprev = 0;

    task automatic model_reset();
        m_pre_oe = 0; m_pre_oen = 0; m_act_oe = 0; m_act_oen = 0; m_dma = 0;
        m_pre_mode = 0; m_act_mode = 0; m_tprev = 0;
    endtask

    task automatic step(input string tag);
        logic xfer;
        @(negedge clk);
        cfg_preload = d_pre; cfg_trig_commute = d_tc; cfg_dma_on_update = d_dsel;
        wr_en = d_wr; wr_chan = d_ch; wr_oe = d_oe; wr_oen = d_oen; wr_mode = d_mode;
        com_strobe = d_stb; trig_in = d_trig; chan_evt = d_chevt; upd_evt = d_upd;
        xfer = d_stb | (d_tc & d_trig & ~m_tprev);
        if (d_wr) begin
            m_pre_oe[d_ch] = d_oe; m_pre_oen[d_ch] = d_oen;
            m_pre_mode[d_ch*MW +: MW] = d_mode;
        end
        if (!d_pre) begin
            if (d_wr) begin
                m_act_oe[d_ch] = d_oe; m_act_oen[d_ch] = d_oen;
                m_act_mode[d_ch*MW +: MW] = d_mode;
            end
        end else if (xfer) begin
            m_act_oe = m_pre_oe; m_act_oen = m_pre_oen; m_act_mode = m_pre_mode;
        end
        m_tprev = d_trig;
        m_dma = d_dsel ? {NCH{d_upd}} : d_chevt;
        exp_q.push_back('{oe: m_act_oe, oen: m_act_oen, mode: m_act_mode, dma: m_dma});
        tag_q.push_back(tag);
        d_wr = 0; d_stb = 0; d_upd = 0; d_chevt = 0;
    endtask

    task automatic put(input logic [1:0] ch, input logic oe, input logic oen,
                       input logic [MW-1:0] mode);
        d_wr = 1; d_ch = ch; d_oe = oe; d_oen = oen; d_mode = mode;
    endtask

    task automatic check_reset();
        checks++;
        if (act_oe != 0 || act_oen != 0 || act_mode != 0 || dma_req != 0) begin
            errors++;
            $display("FAIL R1: got oe=%b oen=%b mode=%h dma=%b exp all zero",
                     act_oe, act_oen, act_mode, dma_req);
        end
    endtask

    // monitor: compare each produced result with the queued expectation
    initial begin
        exp_t  e;
        string t;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({act_oe, act_oen, act_mode, dma_req} != e) begin
                    errors++;
                    $display("FAIL %s: got oe=%b oen=%b mode=%h dma=%b exp oe=%b oen=%b mode=%h dma=%b",
                             t, act_oe, act_oen, act_mode, dma_req, e.oe, e.oen, e.mode, e.dma);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; cfg_preload = 0; cfg_trig_commute = 0; cfg_dma_on_update = 0;
        wr_en = 0; wr_chan = 0; wr_oe = 0; wr_oen = 0; wr_mode = 0;
        com_strobe = 0; trig_in = 0; chan_evt = 0; upd_evt = 0;
        repeat (3) @(negedge clk);
        check_reset();                       // R1 while held
        rst = 0;
        model_reset();
        step("R1");                          // R1 after release

        // direct mode
        put(0, 1, 0, 3'd5); step("R2");
        put(2, 0, 1, 3'd6); step("R2");
        step("R2");
        d_stb = 1; step("R9");
        put(3, 1, 1, 3'd7); d_stb = 1; step("R9");

        // staged mode, strobe commutation
        d_pre = 1;
        put(1, 1, 1, 3'd3); step("R3");
        put(0, 0, 1, 3'd2); step("R3");
        step("R3");
        d_stb = 1; step("R4");
        step("R4");

        // trigger edges ignored while disabled
        put(2, 1, 0, 3'd1); step("R5");
        d_trig = 1; step("R5");
        step("R5");
        d_trig = 0; step("R5");
        d_trig = 1; step("R5");
        d_trig = 0; step("R5");

        // trigger edges commutate when enabled
        d_tc = 1;
        step("R6");
        d_trig = 1; step("R6");
        put(3, 0, 0, 3'd4); step("R6");      // held high: no transfer
        step("R6");
        d_trig = 0; step("R6");              // falling edge: no transfer
        d_trig = 1; step("R6");              // new rise: transfer

        // write together with event
        d_trig = 0; step("R7");
        put(1, 0, 1, 3'd6); d_stb = 1; step("R7");
        put(0, 1, 1, 3'd1); d_trig = 1; step("R7");
        d_trig = 0; d_tc = 0;
        put(2, 1, 1, 3'd7); step("R7");
        put(2, 0, 0, 3'd3); d_stb = 1; step("R7");

        // DMA routing
        d_dsel = 0; d_chevt = 4'b1010; d_upd = 1; step("R8");
        d_chevt = 4'b0101; step("R8");
        d_dsel = 1; d_chevt = 4'b1111; step("R8");
        d_upd = 1; d_chevt = 4'b0011; step("R8");
        d_upd = 1; step("R8");
        d_dsel = 0; step("R8");
        step("R8");

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        check_reset();                       // R1 mid-run reset
        rst = 0;
        #(CLK_PERIOD/4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule